// File: doc/BRIEF.md
# SDRAM Command and Address Issuer

This block sits between a memory controller's scheduler and the control pins of a four-bank, 16-bit synchronous DRAM. The scheduler presents one request at a time on a valid/ready interface. The request can be activate, read, write, precharge of one bank or of all banks, auto-refresh, self-refresh entry or self-refresh exit. The block turns each accepted request into one registered pin cycle: chip select, the three active-low strobes, the bank number, the multiplexed address bus and clock enable. Cycles with no request hold chip select high.

The block places the row or column address on the correct address bits. It puts the precharge option on bit 10, the bit with two meanings. It also drives the two per-byte data masks for each beat of a burst. A write mask appears in the same cycle as its data beat. A read mask is issued two cycles before the beat it suppresses, so each read mask lands at a cycle that depends on the CAS latency. New requests wait until the mask schedule of the previous burst has drained.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: In every cycle after reset in which no request was accepted on the previous edge, cs_n is 1, ras_n/cas_n/we_n are 1, cke is unchanged, ba is 0 and addr is 0. Reset drives cs_n=1, all strobes 1, cke=1 and dqm=0.
- R2: An accepted request appears on the pins one edge later, with strobes (ras_n,cas_n,we_n) as follows: activate (op 1) = 0,1,1; read (op 2) = 1,0,1; write (op 3) = 1,0,0; precharge (op 4) = 0,1,0; auto-refresh (op 5) = 0,0,1; all with cs_n=0. Op 0 (no-op) gives cs_n=1 with all strobes 1.
- R3: On activate, addr carries the full 13-bit row and ba carries the request bank.
- R4: On read or write, addr[8:0] is the column, addr[10] is the auto-precharge flag, addr[9], addr[11] and addr[12] are 0, and ba carries the request bank. The row input is ignored.
- R5: On precharge with the all-banks flag set, addr[10]=1 and ba=0, and the request bank is ignored. With the flag clear, addr[10]=0 and ba is the request bank. All other address bits are 0 on precharge.
- R6: On auto-refresh, ba and addr are 0.
- R7: Mask encoding: req_mask bits [2k+1:2k] are beat k's {upper, lower} mask, and dqm[1] is the upper byte. For a write, beat k's mask is on dqm k cycles after the command cycle.
- R8: For a read with CAS latency CL (default 3), beat k's mask is on dqm (CL-2)+k cycles after the command cycle. dqm is 0 in all cycles that no beat covers.
- R9: req_ready stays low after a read or write until the cycle that shows its last mask beat. It rises in that cycle, so the next command appears right after the last beat.
- R10: Self-refresh entry (op 6) gives cs_n=0 with the auto-refresh strobes and cke=0 in the same cycle. cke stays 0 and the pins stay deselected until an exit request.
- R11: In self-refresh, only an exit request (op 7) is accepted. It gives cke=1 with cs_n=1. An exit request outside self-refresh acts as a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all pins change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be accepted this cycle |
| req_op | input | 3 | Request code (see R2, R10, R11) |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Row address for activate |
| req_col | input | 9 | Column address for read/write |
| req_auto_pre | input | 1 | Auto-precharge after read/write burst |
| req_all_banks | input | 1 | Precharge all banks |
| req_mask | input | 8 | Per-beat byte masks, two bits per beat |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Multiplexed address bus |
| sd_dqm | output | 2 | Byte data masks {upper, lower} |

## Verification
Two functions can drive pins in the same cycle. One is the pin encoding of a newly accepted command. The other is the mask schedule of the burst before it, which for a read runs CL-2 cycles past the burst length. The bench holds a request valid while a read's mask beats are still draining. It checks that the command stays off the pins until the cycle after the last beat, and that the last mask beat is not cut short. It also checks that the write's first mask beat shares its cycle with the write command.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ACT   = 3'd1,
    OP_RD    = 3'd2,
    OP_WR    = 3'd3,
    OP_PRE   = 3'd4,
    OP_REF   = 3'd5,
    OP_SREF  = 3'd6,
    OP_SREX  = 3'd7
  } req_op_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } strobe_t;

  localparam strobe_t STB_IDLE = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

  // Strobe pattern for a request code; idle/exit codes deselect the device.
  function automatic strobe_t strobes_for(input req_op_e op);
    strobe_t s;
    s = STB_IDLE;
    unique case (op)
      OP_ACT:  s = '{1'b0, 1'b0, 1'b1, 1'b1};
      OP_RD:   s = '{1'b0, 1'b1, 1'b0, 1'b1};
      OP_WR:   s = '{1'b0, 1'b1, 1'b0, 1'b0};
      OP_PRE:  s = '{1'b0, 1'b0, 1'b1, 1'b0};
      OP_REF,
      OP_SREF: s = '{1'b0, 1'b0, 1'b0, 1'b1};
      default: s = STB_IDLE;
    endcase
    return s;
  endfunction

  function automatic logic op_is_burst(input req_op_e op);
    return (op == OP_RD) || (op == OP_WR);
  endfunction

endpackage

// File: rtl/sdram_addr_mux.sv
module sdram_addr_mux
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int OPT_BIT = 10
) (
  input  req_op_e             op,
  input  logic [BANK_W-1:0]   bank,
  input  logic [ADDR_W-1:0]   row,
  input  logic [COL_W-1:0]    col,
  input  logic                auto_pre,
  input  logic                all_banks,
  output strobe_t             stb,
  output logic [BANK_W-1:0]   ba,
  output logic [ADDR_W-1:0]   addr
);

  // Column word: column in the low bits, option flag at OPT_BIT, rest zero.
  function automatic logic [ADDR_W-1:0] col_word(input logic [COL_W-1:0] c,
                                                 input logic opt);
    logic [ADDR_W-1:0] w;
    w = '0;
    w[COL_W-1:0] = c;
    w[OPT_BIT] = opt;
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] opt_word(input logic opt);
    logic [ADDR_W-1:0] w;
    w = '0;
    w[OPT_BIT] = opt;
    return w;
  endfunction

  always_comb begin
    stb  = strobes_for(op);
    ba   = '0;
    addr = '0;
    unique case (op)
      OP_ACT: begin
        ba   = bank;
        addr = row;
      end
      OP_RD, OP_WR: begin
        ba   = bank;
        addr = col_word(col, auto_pre);
      end
      OP_PRE: begin
        ba   = all_banks ? '0 : bank;
        addr = opt_word(all_banks);
      end
      default: begin
        ba   = '0;
        addr = '0;
      end
    endcase
  end

endmodule

// File: rtl/sdram_mask_sched.sv
module sdram_mask_sched #(
  parameter int BYTES   = 2,
  parameter int BURST   = 4,
  parameter int CAS_LAT = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    load_rd,
  input  logic [BURST*BYTES-1:0]  beat_mask,
  output logic [BYTES-1:0]        dqm,
  output logic                    busy
);

  localparam int RD_OFF  = CAS_LAT - 2;
  localparam int SLOTS   = RD_OFF + BURST;
  localparam int CNT_W   = $clog2(SLOTS + 1);
  localparam int WR_SPAN = BURST;
  localparam int RD_SPAN = SLOTS;

  logic [SLOTS*BYTES-1:0] slot_q, slot_load;
  logic [CNT_W-1:0]       left_q;

  // Place beat k at slot k (write) or slot RD_OFF+k (read).
  always_comb begin
    slot_load = '0;
    for (int k = 0; k < BURST; k++) begin
      if (load_rd)
        slot_load[(RD_OFF+k)*BYTES +: BYTES] = beat_mask[k*BYTES +: BYTES];
      else
        slot_load[k*BYTES +: BYTES] = beat_mask[k*BYTES +: BYTES];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      left_q <= '0;
    end else if (load) begin
      slot_q <= slot_load;
      left_q <= load_rd ? CNT_W'(RD_SPAN - 1) : CNT_W'(WR_SPAN - 1);
    end else begin
      slot_q <= slot_q >> BYTES;
      if (left_q != '0) left_q <= left_q - 1'b1;
    end
  end

  assign dqm  = slot_q[BYTES-1:0];
  assign busy = (left_q != '0);

endmodule

// File: rtl/sdram_cke_ctrl.sv
module sdram_cke_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic enter,
  input  logic leave,
  output logic cke,
  output logic in_sr
);

  always_ff @(posedge clk) begin
    if (rst)        in_sr <= 1'b0;
    else if (enter) in_sr <= 1'b1;
    else if (leave) in_sr <= 1'b0;
  end

  assign cke = ~in_sr;

endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
  import sdram_cmd_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int COL_W   = 9,
  parameter int BANK_W  = 2,
  parameter int OPT_BIT = 10,
  parameter int BYTES   = 2,
  parameter int BURST   = 4,
  parameter int CAS_LAT = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [2:0]              req_op,
  input  logic [BANK_W-1:0]       req_bank,
  input  logic [ADDR_W-1:0]       req_row,
  input  logic [COL_W-1:0]        req_col,
  input  logic                    req_auto_pre,
  input  logic                    req_all_banks,
  input  logic [BURST*BYTES-1:0]  req_mask,
  output logic                    sd_cke,
  output logic                    sd_cs_n,
  output logic                    sd_ras_n,
  output logic                    sd_cas_n,
  output logic                    sd_we_n,
  output logic [BANK_W-1:0]       sd_ba,
  output logic [ADDR_W-1:0]       sd_addr,
  output logic [BYTES-1:0]        sd_dqm
);

  req_op_e            op;
  strobe_t            mux_stb, pin_stb;
  logic [BANK_W-1:0]  mux_ba;
  logic [ADDR_W-1:0]  mux_addr;
  logic               mask_busy, in_sr;
  logic               accept, acc_burst, acc_rd, acc_sref, acc_srex;

  assign op = req_op_e'(req_op);

  // Self-refresh admits only its exit; otherwise wait for mask drain.
  assign req_ready = in_sr ? (op == OP_SREX) : ~mask_busy;
  assign accept    = req_valid & req_ready;
  assign acc_burst = accept & op_is_burst(op);
  assign acc_rd    = accept & (op == OP_RD);
  assign acc_sref  = accept & (op == OP_SREF);
  assign acc_srex  = accept & (op == OP_SREX) & in_sr;

  sdram_addr_mux #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W), .OPT_BIT(OPT_BIT)
  ) u_mux (
    .op(op), .bank(req_bank), .row(req_row), .col(req_col),
    .auto_pre(req_auto_pre), .all_banks(req_all_banks),
    .stb(mux_stb), .ba(mux_ba), .addr(mux_addr)
  );

  sdram_mask_sched #(
    .BYTES(BYTES), .BURST(BURST), .CAS_LAT(CAS_LAT)
  ) u_mask (
    .clk(clk), .rst(rst), .load(acc_burst), .load_rd(acc_rd),
    .beat_mask(req_mask), .dqm(sd_dqm), .busy(mask_busy)
  );

  sdram_cke_ctrl u_cke (
    .clk(clk), .rst(rst), .enter(acc_sref), .leave(acc_srex),
    .cke(sd_cke), .in_sr(in_sr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_stb <= STB_IDLE;
      sd_ba   <= '0;
      sd_addr <= '0;
    end else if (accept) begin
      pin_stb <= mux_stb;
      sd_ba   <= mux_ba;
      sd_addr <= mux_addr;
    end else begin
      pin_stb <= STB_IDLE;
      sd_ba   <= '0;
      sd_addr <= '0;
    end
  end

  assign sd_cs_n  = pin_stb.cs_n;
  assign sd_ras_n = pin_stb.ras_n;
  assign sd_cas_n = pin_stb.cas_n;
  assign sd_we_n  = pin_stb.we_n;

endmodule

// File: rtl/sdram_cmd_issuer_chk.sv
module sdram_cmd_issuer_chk #(
  parameter int ADDR_W  = 13,
  parameter int BYTES   = 2,
  parameter int BURST   = 4,
  parameter int OPT_BIT = 10
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   accept,
  input logic [2:0]             req_op,
  input logic                   req_auto_pre,
  input logic                   req_all_banks,
  input logic [BURST*BYTES-1:0] req_mask,
  input logic                   req_ready,
  input logic                   mask_busy,
  input logic                   sd_cke,
  input logic                   sd_cs_n,
  input logic                   sd_ras_n,
  input logic                   sd_cas_n,
  input logic                   sd_we_n,
  input logic [1:0]             sd_ba,
  input logic [ADDR_W-1:0]      sd_addr,
  input logic [BYTES-1:0]       sd_dqm
);

  a_r1_idle_deselect: assert property (@(posedge clk) disable iff (rst)
    !accept |=> sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n);

  a_r2_act_strobes: assert property (@(posedge clk) disable iff (rst)
    accept && req_op == 3'd1 |=> !sd_cs_n && !sd_ras_n && sd_cas_n && sd_we_n);

  a_r4_col_option: assert property (@(posedge clk) disable iff (rst)
    accept && (req_op == 3'd2 || req_op == 3'd3)
    |=> sd_addr[OPT_BIT] == $past(req_auto_pre) && sd_addr[ADDR_W-1:OPT_BIT+1] == '0
        && sd_addr[OPT_BIT-1] == 1'b0);

  a_r5_all_banks: assert property (@(posedge clk) disable iff (rst)
    accept && req_op == 3'd4 && req_all_banks |=> sd_addr[OPT_BIT] && sd_ba == 2'd0);

  a_r7_write_mask_now: assert property (@(posedge clk) disable iff (rst)
    accept && req_op == 3'd3 |=> sd_dqm == $past(req_mask[BYTES-1:0]));

  a_r9_hold_off: assert property (@(posedge clk) disable iff (rst)
    mask_busy |-> !req_ready);

  a_r10_sref_entry: assert property (@(posedge clk) disable iff (rst)
    accept && req_op == 3'd6 |=> !sd_cke && !sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n);

  a_r10_sref_hold: assert property (@(posedge clk) disable iff (rst)
    !sd_cke && !accept |=> !sd_cke);

endmodule

bind sdram_cmd_issuer sdram_cmd_issuer_chk #(
  .ADDR_W(ADDR_W), .BYTES(BYTES), .BURST(BURST), .OPT_BIT(OPT_BIT)
) u_chk (
  .clk(clk), .rst(rst), .accept(accept), .req_op(req_op),
  .req_auto_pre(req_auto_pre), .req_all_banks(req_all_banks),
  .req_mask(req_mask), .req_ready(req_ready), .mask_busy(mask_busy),
  .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
  .sd_addr(sd_addr), .sd_dqm(sd_dqm)
);

// File: tb/sdram_cmd_issuer_tb.sv
module sdram_cmd_issuer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CL = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0;
  logic [1:0] req_bank = '0;
  logic [12:0] req_row = '0;
  logic [8:0] req_col = '0;
  logic req_auto_pre = 1'b0, req_all_banks = 1'b0;
  logic [7:0] req_mask = '0;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba, sd_dqm;
  logic [12:0] sd_addr;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_issuer #(.CAS_LAT(CL)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_auto_pre(req_auto_pre), .req_all_banks(req_all_banks), .req_mask(req_mask),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  bank;
    logic [12:0] row;
    logic [8:0]  col;
    logic        ap;
    logic        all;
    logic [3:0]  stb;   // cs_n, ras_n, cas_n, we_n
    logic [1:0]  ba;
    logic [12:0] addr;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 2'd2, 13'h1ABC, 9'h000, 1'b0, 1'b0, 4'b0011, 2'd2, 13'h1ABC}, // R3 activate
    '{3'd2, 2'd1, 13'h1FFF, 9'h1FF, 1'b0, 1'b0, 4'b0101, 2'd1, 13'h01FF}, // R4 read, row ignored
    '{3'd2, 2'd3, 13'h0000, 9'h155, 1'b1, 1'b0, 4'b0101, 2'd3, 13'h0555}, // R4 read + AP
    '{3'd3, 2'd0, 13'h1FFF, 9'h0AA, 1'b1, 1'b0, 4'b0100, 2'd0, 13'h04AA}, // R4 write + AP
    '{3'd3, 2'd2, 13'h0000, 9'h100, 1'b0, 1'b1, 4'b0100, 2'd2, 13'h0100}, // R4 write
    '{3'd4, 2'd3, 13'h1FFF, 9'h1FF, 1'b1, 1'b0, 4'b0010, 2'd3, 13'h0000}, // R5 one bank
    '{3'd4, 2'd1, 13'h1FFF, 9'h1FF, 1'b0, 1'b1, 4'b0010, 2'd0, 13'h0400}, // R5 all banks
    '{3'd5, 2'd3, 13'h1FFF, 9'h1FF, 1'b1, 1'b1, 4'b0001, 2'd0, 13'h0000}, // R6 refresh
    '{3'd0, 2'd3, 13'h1FFF, 9'h1FF, 1'b1, 1'b1, 4'b1111, 2'd0, 13'h0000}, // R2 no-op
    '{3'd1, 2'd0, 13'h0000, 9'h1FF, 1'b1, 1'b1, 4'b0011, 2'd0, 13'h0000}, // R3 row zero
    '{3'd7, 2'd1, 13'h1FFF, 9'h1FF, 1'b1, 1'b1, 4'b1111, 2'd0, 13'h0000}  // R11 exit outside SR
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, wait for ready, return at the falling edge after acceptance.
  task automatic issue(input logic [2:0] op, input logic [1:0] bank, input logic [12:0] row,
                       input logic [8:0] col, input logic ap, input logic all,
                       input logic [7:0] mask);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_bank = bank; req_row = row;
    req_col = col; req_auto_pre = ap; req_all_banks = all; req_mask = mask;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [3:0] pins();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 reset pins", {pins(), sd_cke, sd_dqm}, {4'b1111, 1'b1, 2'b00});
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {pins(), sd_ba, sd_addr}, {4'b1111, 2'd0, 13'd0});

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].bank, VECS[i].row, VECS[i].col, VECS[i].ap, VECS[i].all, 8'h00);
      chk($sformatf("R2 strobes vec %0d", i), pins(), VECS[i].stb);
      chk($sformatf("R3 R4 R5 R6 address vec %0d", i), {sd_ba, sd_addr}, {VECS[i].ba, VECS[i].addr});
      chk($sformatf("R11 cke vec %0d", i), sd_cke, 1'b1);
      @(negedge clk);
      chk($sformatf("R1 deselect after vec %0d", i), pins(), 4'b1111);
    end

    // R7 write mask timing: beats 01,10,11,00
    issue(3'd3, 2'd1, 13'h0, 9'h010, 1'b0, 1'b0, 8'b00_11_10_01);
    chk("R7 write beat0 with command", {pins(), sd_dqm}, {4'b0100, 2'b01});
    chk("R9 ready low in burst", req_ready, 1'b0);
    @(negedge clk); chk("R7 write beat1", sd_dqm, 2'b10);
    @(negedge clk); chk("R7 write beat2", sd_dqm, 2'b11);
    @(negedge clk); chk("R7 write beat3", sd_dqm, 2'b00);
    chk("R9 ready at last write beat", req_ready, 1'b1);
    @(negedge clk); chk("R8 dqm zero after burst", sd_dqm, 2'b00);

    // R8/R9 read mask timing with held-off activate
    issue(3'd2, 2'd2, 13'h0, 9'h020, 1'b0, 1'b0, 8'b10_01_11_01);
    chk("R8 read cmd cycle dqm clear", sd_dqm, 2'b00);
    req_valid = 1'b1; req_op = 3'd1; req_bank = 2'd3; req_row = 13'h0F0F;
    @(negedge clk); chk("R8 read beat0 mask", sd_dqm, 2'b01);
    chk("R9 activate held off", sd_cs_n, 1'b1);
    @(negedge clk); chk("R8 read beat1 mask", sd_dqm, 2'b11);
    @(negedge clk); chk("R8 read beat2 mask", sd_dqm, 2'b01);
    chk("R9 ready still low", req_ready, 1'b0);
    @(negedge clk); chk("R8 read beat3 mask", sd_dqm, 2'b10);
    chk("R9 activate still held", sd_cs_n, 1'b1);
    chk("R9 ready at last read beat", req_ready, 1'b1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 activate after drain", {pins(), sd_ba, sd_addr}, {4'b0011, 2'd3, 13'h0F0F});
    chk("R8 dqm clear after read", sd_dqm, 2'b00);

    // R10/R11 self-refresh
    issue(3'd6, 2'd2, 13'h1FFF, 9'h1FF, 1'b1, 1'b1, 8'h00);
    chk("R10 entry pins", {pins(), sd_cke, sd_ba, sd_addr}, {4'b0001, 1'b0, 2'd0, 13'd0});
    req_valid = 1'b1; req_op = 3'd1;
    @(negedge clk);
    chk("R11 non-exit refused in SR", req_ready, 1'b0);
    repeat (3) @(negedge clk);
    chk("R10 cke held low", {sd_cke, pins()}, {1'b0, 4'b1111});
    req_op = 3'd7;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 exit pins", {sd_cke, pins()}, {1'b1, 4'b1111});
    @(negedge clk);
    chk("R11 cke stays high", sd_cke, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule